// File: doc/BRIEF.md
# Interrupt Register Bank with Software Test Forcing

This block gathers up to sixteen single-cycle event pulses into sticky status bits. It gates them with an enable mask and drives one active-low interrupt request line toward a processor. The processor reaches it through a simple single-cycle register port: a write strobe with address and data, and a read data bus that always shows the register currently addressed.

Beside the hardware status, software can load a test register. Its bits are ORed onto the status before the mask is applied, so every interrupt path can be exercised without real events. A write-only clear register removes pending bits from both the status and the test register in one write. The status register reads back the OR of hardware and test bits. A separate read-only register shows the masked result that drives the request line.

Register offsets (byte addresses on `addr_i`):
- 0x00: masked request, read-only
- 0x04: enable mask, read/write
- 0x08: test, read/write
- 0x0C: status, read-only
- 0x10: clear, write-only

Top module: `irq_regbank`

## Requirements
- R1: After reset, every register reads 0 and `irq_no` is 1.
- R2: A write to offset 0x04 loads the enable mask. A read of 0x04 returns the value last written.
- R3: A write to offset 0x08 loads the test register. A read of 0x08 returns the value last written.
- R4: Status bit k becomes 1 in the cycle after `evt_i[k]` is 1 at a clock edge. It stays 1 until it is cleared.
- R5: A read of offset 0x0C returns the bitwise OR of the status bits and the test bits.
- R6: A read of offset 0x00 returns (status OR test) AND enable, bit by bit.
- R7: `irq_no` is 0 whenever any bit of the masked value from R6 is 1, and 1 when all of those bits are 0. This includes the case where a test bit is written back to 0.
- R8: A write of value c to offset 0x10 zeroes, in the next cycle, every status bit and every test bit where c has a 1. All other bits are left unchanged.
- R9: When `evt_i[k]` and a clear write with bit k set occur at the same clock edge, status bit k is 1 afterwards.
- R10: Reads of offset 0x10, and of any unmapped offset, return 0. Writes to offsets 0x00 and 0x0C change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Event pulses, one per interrupt source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for the register at `addr_i` |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the assertions check:
- that an event pulse lands in the status register;
- that status bits only fall on a clear write;
- that a clear write empties the cleared test and status bits unless an event arrives at the same edge;
- that enable writes take effect;
- that the request line agrees with the masked read value whenever offset 0 is addressed;
- that the clear offset reads zero.

Only the bench scenarios can show the rest: each of the sixteen bits taken separately through event, test, enable and clear, the tie between an event and a clear on the same bit, and the fact that writes to read-only offsets leave every register unchanged.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int OFF_MASKED = 'h00;
  localparam int OFF_ENA    = 'h04;
  localparam int OFF_TST    = 'h08;
  localparam int OFF_STS    = 'h0C;
  localparam int OFF_CLR    = 'h10;

  typedef enum logic [2:0] {
    SEL_MASKED,
    SEL_ENA,
    SEL_TST,
    SEL_STS,
    SEL_CLR,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    if      (addr_i == ADDR_W'(OFF_MASKED)) sel_o = SEL_MASKED;
    else if (addr_i == ADDR_W'(OFF_ENA))    sel_o = SEL_ENA;
    else if (addr_i == ADDR_W'(OFF_TST))    sel_o = SEL_TST;
    else if (addr_i == ADDR_W'(OFF_STS))    sel_o = SEL_STS;
    else if (addr_i == ADDR_W'(OFF_CLR))    sel_o = SEL_CLR;
    else                                    sel_o = SEL_NONE;
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] sts_o
);
  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    // event wins over a same-cycle clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sts_o[k] <= 1'b0;
      else         sts_o[k] <= evt_i[k] | (sts_o[k] & ~clr_i[k]);
    end
  end
endmodule

// File: rtl/irq_rw_reg.sv
module irq_rw_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
    else           q_o <= q_o & ~clr_i;
  end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] masked_i,
  input  logic [DATA_W-1:0] ena_i,
  input  logic [DATA_W-1:0] tst_i,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    unique case (sel_i)
      SEL_MASKED: rdata_o = masked_i;
      SEL_ENA:    rdata_o = ena_i;
      SEL_TST:    rdata_o = tst_i;
      SEL_STS:    rdata_o = raw_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_regbank.sv
module irq_regbank
  import irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] evt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_no
);
  reg_sel_e          sel;
  logic [DATA_W-1:0] clr_vec, sts_q, tst_q, ena_q, raw, masked;
  logic              wr_ena, wr_tst;

  irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (.addr_i(addr_i), .sel_o(sel));

  assign wr_ena  = we_i && (sel == SEL_ENA);
  assign wr_tst  = we_i && (sel == SEL_TST);
  assign clr_vec = (we_i && (sel == SEL_CLR)) ? wdata_i : '0;

  irq_status_reg #(.DATA_W(DATA_W)) u_sts (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .clr_i(clr_vec), .sts_o(sts_q)
  );

  irq_rw_reg #(.DATA_W(DATA_W)) u_tst (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_tst), .wdata_i(wdata_i),
    .clr_i(clr_vec), .q_o(tst_q)
  );

  irq_rw_reg #(.DATA_W(DATA_W)) u_ena (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_ena), .wdata_i(wdata_i),
    .clr_i('0), .q_o(ena_q)
  );

  assign raw    = sts_q | tst_q;
  assign masked = raw & ena_q;
  assign irq_no = ~|masked;

  irq_read_mux #(.DATA_W(DATA_W)) u_rd (
    .sel_i(sel), .masked_i(masked), .ena_i(ena_q), .tst_i(tst_q),
    .raw_i(raw), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/irq_regbank_chk.sv
module irq_regbank_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] evt_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_no,
  input logic [DATA_W-1:0] sts_q,
  input logic [DATA_W-1:0] tst_q,
  input logic [DATA_W-1:0] ena_q
);
  logic clr_wr, ena_wr;
  assign clr_wr = we_i && (addr_i == ADDR_W'(irq_pkg::OFF_CLR));
  assign ena_wr = we_i && (addr_i == ADDR_W'(irq_pkg::OFF_ENA));

  p_evt_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> (((tst_q & $past(wdata_i)) == '0) &&
                ((sts_q & $past(wdata_i) & ~$past(evt_i)) == '0)));

  p_ena_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ena_wr |=> (ena_q == $past(wdata_i)));

  p_irq_line_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(irq_pkg::OFF_MASKED)) |-> (irq_no == (rdata_o == '0)));

  p_clr_reads_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(irq_pkg::OFF_CLR)) |-> (rdata_o == '0));
endmodule

bind irq_regbank irq_regbank_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_no(irq_no),
  .sts_q(sts_q), .tst_q(tst_q), .ena_q(ena_q)
);

// File: tb/sim_irq_regbank.sv
module sim_irq_regbank;
  localparam int W = 16;
  localparam int A = 5;
  localparam logic [A-1:0] O_MSK = 5'h00, O_ENA = 5'h04, O_TST = 5'h08,
                           O_STS = 5'h0C, O_CLR = 5'h10;

  logic         clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0;
  logic [W-1:0] evt_i = '0, wdata_i = '0, rdata_o;
  logic [A-1:0] addr_i = '0;
  logic         irq_no;
  int           n_chk = 0, n_bad = 0;

  irq_regbank u0 (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [A-1:0] a, input logic [W-1:0] d);
    @(negedge clk_i); we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i); we_i = 1'b0;
  endtask

  task automatic rd(input logic [A-1:0] a, output logic [W-1:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic pulse(input logic [W-1:0] v);
    @(negedge clk_i); evt_i = v;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    #12 rst_ni = 1'b1;
    // R1 reset state
    rd(O_MSK, v); chk("R1 masked", v, '0);
    rd(O_ENA, v); chk("R1 ena", v, '0);
    rd(O_TST, v); chk("R1 tst", v, '0);
    rd(O_STS, v); chk("R1 sts", v, '0);
    chk("R1 irq_no", {15'b0, irq_no}, 16'h1);

    // per-bit sweep over hardware events
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] b;
      b = 16'h1 << k;
      pulse(b);
      @(negedge clk_i);
      rd(O_STS, v); chk("R4 sticky", v, b);
      rd(O_MSK, v); chk("R6 masked off", v, '0);
      chk("R7 idle", {15'b0, irq_no}, 16'h1);
      wr(O_ENA, b);
      rd(O_ENA, v); chk("R2 ena rb", v, b);
      rd(O_MSK, v); chk("R6 masked on", v, b);
      chk("R7 asserted", {15'b0, irq_no}, 16'h0);
      wr(O_CLR, b);
      rd(O_STS, v); chk("R8 sts cleared", v, '0);
      chk("R7 released", {15'b0, irq_no}, 16'h1);
      wr(O_ENA, '0);
    end

    // per-bit sweep over test register
    for (int k = 0; k < W; k++) begin
      logic [W-1:0] b, t;
      b = 16'h1 << k;
      t = b | 16'h8001;
      wr(O_TST, t);
      rd(O_TST, v); chk("R3 tst rb", v, t);
      rd(O_STS, v); chk("R5 sts or tst", v, t);
      wr(O_ENA, b);
      rd(O_MSK, v); chk("R6 tst masked", v, b);
      chk("R7 tst assert", {15'b0, irq_no}, 16'h0);
      wr(O_TST, t & ~b);
      chk("R7 tst zero back", {15'b0, irq_no}, 16'h1);
      wr(O_TST, t);
      wr(O_CLR, b);
      rd(O_TST, v); chk("R8 tst cleared", v, t & ~b);
      wr(O_CLR, 16'hFFFF);
      rd(O_TST, v); chk("R8 tst all cleared", v, '0);
      wr(O_ENA, '0);
    end

    // R5 mixed status and test, R8 partial clear keeps others
    pulse(16'h00F0);
    wr(O_TST, 16'h0F00);
    rd(O_STS, v); chk("R5 mixed", v, 16'h0FF0);
    wr(O_CLR, 16'h0330);
    rd(O_STS, v); chk("R8 partial", v, 16'h0CC0);
    rd(O_TST, v); chk("R8 partial tst", v, 16'h0C00);
    wr(O_CLR, 16'hFFFF);

    // R9 event and clear on same bit at same edge
    pulse(16'h0008);
    @(negedge clk_i); we_i = 1'b1; addr_i = O_CLR; wdata_i = 16'h0008; evt_i = 16'h0008;
    @(negedge clk_i); we_i = 1'b0; evt_i = '0;
    rd(O_STS, v); chk("R9 tie keeps set", v, 16'h0008);
    wr(O_CLR, 16'h0008);
    rd(O_STS, v); chk("R9 later clear", v, '0);

    // R10 read-only writes ignored, clear/unmapped read zero
    wr(O_ENA, 16'h00FF);
    wr(O_TST, 16'h0011);
    wr(O_MSK, 16'hFFFF);
    wr(O_STS, 16'hFFFF);
    rd(O_ENA, v); chk("R10 ena kept", v, 16'h00FF);
    rd(O_TST, v); chk("R10 tst kept", v, 16'h0011);
    rd(O_STS, v); chk("R10 sts kept", v, 16'h0011);
    rd(O_MSK, v); chk("R10 masked kept", v, 16'h0011);
    rd(O_CLR, v); chk("R10 clr reads 0", v, '0);
    rd(5'h14, v); chk("R10 unmapped", v, '0);
    rd(5'h02, v); chk("R10 unaligned", v, '0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule